// File: doc/BRIEF.md
# Address Header Transmitter

This block is controller-side logic that sends the nine-bit address header that opens every transaction, right after a Start or a Restart condition. A command supplies a 7-bit target address, a read/write flag and a flag that says whether the header follows a Restart. The block places one bit on SDA per bit slot. It drives SDA as a data value plus an output-enable. For each bit it picks either open-drain signalling (drive low or release) or push-pull signalling (drive both levels).

The SCL timing comes from outside the block as two single-cycle strobes. One strobe marks where the next bit must be placed on the line, while SCL is low. The other marks where the line is read, while SCL is high. Headers that follow a Start can be contested by other devices, so they go out open-drain, and the block watches for a released bit being pulled low; it only flags that case. Headers that follow a Restart go out push-pull. The ninth slot is always released, so the target can answer. The block then reports whether the target acknowledged, together with a one-cycle completion pulse.

Top module: `addr_header_tx`

## Requirements
- R1: A command is accepted when `cmdValid` is high while `busy` is low, and `busy` is high from the next cycle. Any `cmdValid` or command field change while `busy` is high is ignored, and the header in progress is unchanged.
- R2: Each `bitDrive` pulse puts the next header bit on the line, visible from the following cycle. The order is the address from bit 6 down to bit 0, then the read/write bit, then the acknowledge slot.
- R3: When `cmdAfterRestart` was 0 at accept, the eight first bits go out open-drain. A 0 gives `sdaOe`=1 with `sdaOut`=0. A 1 gives `sdaOe`=0. SDA is never driven high, and `pushPull` stays 0.
- R4: When `cmdAfterRestart` was 1 at accept, the eight first bits go out push-pull: `sdaOe`=1, `sdaOut` equals the bit, and `pushPull`=1 while such a bit is on the line.
- R5: The read/write bit is 1 when `cmdRead`=1 (read) and 0 for a write. It is sent in the same signalling mode as the address bits.
- R6: During the ninth slot `sdaOe` is 0, whatever the mode of the header.
- R7: The `bitSample` of the ninth slot raises `done` for exactly one cycle in the following cycle. In that same cycle `busy` falls and `ackReceived` shows 1 if SDA was sampled low and 0 if it was high. `ackReceived` then holds until the next accept.
- R8: In an open-drain header, if a released bit is sampled low, `arbLost` rises in the following cycle and stays high until the next accept. `sdaOe` stays 0 for the remaining bits, and the header still runs to its acknowledge slot. A push-pull header never raises `arbLost`.
- R9: After reset `busy`, `done`, `sdaOe`, `sdaOut`, `pushPull`, `arbLost` and `ackReceived` are all 0.
- R10: A `bitSample` pulse that arrives while the block waits for `bitDrive` is ignored. It neither advances the header nor samples SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Request to start a header |
| cmdAddr | input | 7 | Target address |
| cmdRead | input | 1 | 1 = read, 0 = write |
| cmdAfterRestart | input | 1 | 1 = header follows a Restart (push-pull), 0 = follows a Start (open-drain) |
| busy | output | 1 | Header in progress |
| bitDrive | input | 1 | SCL-low strobe: present the next bit |
| bitSample | input | 1 | SCL-high strobe: read SDA |
| sdaIn | input | 1 | Resolved SDA line level |
| sdaOut | output | 1 | Value driven on SDA when enabled |
| sdaOe | output | 1 | SDA output-enable |
| pushPull | output | 1 | Current bit is driven push-pull |
| done | output | 1 | One-cycle pulse after the acknowledge slot is sampled |
| ackReceived | output | 1 | Target acknowledged (SDA low in ninth slot) |
| arbLost | output | 1 | A released open-drain bit was read low |

## Verification
The embedded properties assume that `bitDrive` and `bitSample` are single-cycle pulses that alternate, with at least one cycle between them. They also assume that `sdaIn` is settled when `bitSample` is high. The bench drives every strobe for one cycle from the falling clock edge and changes `sdaIn` only between slots. It models the bus as the block's own driven level, or as a released-high line that the responder or a competing device can pull low. One scenario deliberately sends an out-of-order `bitSample` and a mid-header command, to show that the block ignores them.

// File: rtl/addr_hdr_pkg.sv
package addr_hdr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DRIVE  = 2'd1,
    ST_SAMPLE = 2'd2
  } hdrState_t;

  // Strobes from the sequencer to the datapath, at most one high per cycle
  typedef struct packed {
    logic load;       // capture a new command
    logic driveBit;   // present the current header bit
    logic sampleBit;  // read SDA for a header bit, advance
    logic driveAck;   // release SDA for the acknowledge slot
    logic sampleAck;  // read SDA for the acknowledge slot
  } hdrStrobe_t;

endpackage

// File: rtl/addr_hdr_ctrl.sv
module addr_hdr_ctrl
  import addr_hdr_pkg::*;
#(
  parameter int HDR_BITS = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       bitDrive,
  input  logic       bitSample,
  output hdrStrobe_t strb,
  output logic       busy,
  output logic       done
);

  localparam int CNT_W = $clog2(HDR_BITS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(HDR_BITS - 1);

  hdrState_t        state;
  logic [CNT_W-1:0] bitCnt;
  logic             lastSlot;

  assign lastSlot = (bitCnt == LAST_IDX);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    strb = '0;
    unique case (state)
      ST_IDLE:   strb.load = cmdValid;
      ST_DRIVE: begin
        if (bitDrive) begin
          if (lastSlot) strb.driveAck = 1'b1;
          else          strb.driveBit = 1'b1;
        end
      end
      ST_SAMPLE: begin
        if (bitSample) begin
          if (lastSlot) strb.sampleAck = 1'b1;
          else          strb.sampleBit = 1'b1;
        end
      end
      default: strb = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      done   <= 1'b0;
    end else begin
      done <= strb.sampleAck;
      unique case (state)
        ST_IDLE: begin
          if (strb.load) begin
            bitCnt <= '0;
            state  <= ST_DRIVE;
          end
        end
        ST_DRIVE: begin
          if (strb.driveBit || strb.driveAck) state <= ST_SAMPLE;
        end
        ST_SAMPLE: begin
          if (strb.sampleAck) begin
            state <= ST_IDLE;
          end else if (strb.sampleBit) begin
            bitCnt <= bitCnt + 1'b1;
            state  <= ST_DRIVE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: an accepted command makes the block busy in the next cycle
  a_r1_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdValid) |=> busy);

  // R7: completion is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: completion coincides with the block going idle
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R10: a sample strobe while waiting to drive leaves the sequencer in place
  a_r10_stray_sample: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DRIVE && !bitDrive) |=> (state == ST_DRIVE && $stable(bitCnt)));

endmodule

// File: rtl/addr_hdr_dpath.sv
module addr_hdr_dpath
  import addr_hdr_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  hdrStrobe_t        strb,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              cmdRead,
  input  logic              cmdAfterRestart,
  input  logic              sdaIn,
  output logic              sdaOut,
  output logic              sdaOe,
  output logic              pushPull,
  output logic              arbLost,
  output logic              ackReceived
);

  localparam int SHIFT_W = ADDR_W + 1;

  logic [SHIFT_W-1:0] shiftReg;
  logic               modePP;
  logic               curBit;
  logic               nextBit;

  assign nextBit = shiftReg[SHIFT_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg    <= '0;
      modePP      <= 1'b0;
      curBit      <= 1'b0;
      sdaOut      <= 1'b0;
      sdaOe       <= 1'b0;
      pushPull    <= 1'b0;
      arbLost     <= 1'b0;
      ackReceived <= 1'b0;
    end else begin
      if (strb.load) begin
        shiftReg    <= {cmdAddr, cmdRead};
        modePP      <= cmdAfterRestart;
        curBit      <= 1'b0;
        sdaOut      <= 1'b0;
        sdaOe       <= 1'b0;
        pushPull    <= 1'b0;
        arbLost     <= 1'b0;
        ackReceived <= 1'b0;
      end
      if (strb.driveBit) begin
        curBit <= nextBit;
        if (arbLost) begin
          sdaOe    <= 1'b0;
          sdaOut   <= 1'b0;
          pushPull <= 1'b0;
        end else if (modePP) begin
          sdaOe    <= 1'b1;
          sdaOut   <= nextBit;
          pushPull <= 1'b1;
        end else begin
          sdaOe    <= ~nextBit;
          sdaOut   <= 1'b0;
          pushPull <= 1'b0;
        end
      end
      if (strb.sampleBit) begin
        shiftReg <= shiftReg << 1;
        if (!modePP && curBit && !sdaIn) arbLost <= 1'b1;
      end
      if (strb.driveAck) begin
        sdaOe    <= 1'b0;
        sdaOut   <= 1'b0;
        pushPull <= 1'b0;
      end
      if (strb.sampleAck) ackReceived <= ~sdaIn;
    end
  end

  // R6: the acknowledge slot is always released
  a_r6_ack_released: assert property (@(posedge clk) disable iff (!rstN)
    strb.driveAck |=> !sdaOe);

  // R3: an open-drain header never drives SDA high
  a_r3_od_never_high: assert property (@(posedge clk) disable iff (!rstN)
    !modePP |-> !(sdaOe && sdaOut));

  // R8: after losing the bus the block stays off the line
  a_r8_silent_after_loss: assert property (@(posedge clk) disable iff (!rstN)
    arbLost |-> !sdaOe);

  // R8: push-pull headers cannot lose arbitration
  a_r8_pp_no_loss: assert property (@(posedge clk) disable iff (!rstN)
    modePP |-> !arbLost);

  // R4: a push-pull bit is actively driven
  a_r4_pp_drives: assert property (@(posedge clk) disable iff (!rstN)
    (strb.driveBit && modePP) |=> (sdaOe && pushPull));

endmodule

// File: rtl/addr_header_tx.sv
module addr_header_tx
  import addr_hdr_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              cmdRead,
  input  logic              cmdAfterRestart,
  output logic              busy,
  input  logic              bitDrive,
  input  logic              bitSample,
  input  logic              sdaIn,
  output logic              sdaOut,
  output logic              sdaOe,
  output logic              pushPull,
  output logic              done,
  output logic              ackReceived,
  output logic              arbLost
);

  localparam int HDR_BITS = ADDR_W + 2;

  hdrStrobe_t strb;

  addr_hdr_ctrl #(
    .HDR_BITS (HDR_BITS)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .bitDrive  (bitDrive),
    .bitSample (bitSample),
    .strb      (strb),
    .busy      (busy),
    .done      (done)
  );

  addr_hdr_dpath #(
    .ADDR_W (ADDR_W)
  ) dpath_i (
    .clk             (clk),
    .rstN            (rstN),
    .strb            (strb),
    .cmdAddr         (cmdAddr),
    .cmdRead         (cmdRead),
    .cmdAfterRestart (cmdAfterRestart),
    .sdaIn           (sdaIn),
    .sdaOut          (sdaOut),
    .sdaOe           (sdaOe),
    .pushPull        (pushPull),
    .arbLost         (arbLost),
    .ackReceived     (ackReceived)
  );

endmodule

// File: tb/addr_header_tx_tb_top.sv
module addr_header_tx_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [6:0] cmdAddr = '0;
  logic       cmdRead = 1'b0;
  logic       cmdAfterRestart = 1'b0;
  logic       busy;
  logic       bitDrive = 1'b0;
  logic       bitSample = 1'b0;
  logic       sdaIn = 1'b1;
  logic       sdaOut;
  logic       sdaOe;
  logic       pushPull;
  logic       done;
  logic       ackReceived;
  logic       arbLost;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  addr_header_tx dut_i (
    .clk             (clk),
    .rstN            (rstN),
    .cmdValid        (cmdValid),
    .cmdAddr         (cmdAddr),
    .cmdRead         (cmdRead),
    .cmdAfterRestart (cmdAfterRestart),
    .busy            (busy),
    .bitDrive        (bitDrive),
    .bitSample       (bitSample),
    .sdaIn           (sdaIn),
    .sdaOut          (sdaOut),
    .sdaOe           (sdaOe),
    .pushPull        (pushPull),
    .done            (done),
    .ackReceived     (ackReceived),
    .arbLost         (arbLost)
  );

  task automatic chkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // R9: reset state
  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chkEq("R9", "busy", busy, 0);
    chkEq("R9", "done", done, 0);
    chkEq("R9", "sdaOe", sdaOe, 0);
    chkEq("R9", "sdaOut", sdaOut, 0);
    chkEq("R9", "pushPull", pushPull, 0);
    chkEq("R9", "arbLost", arbLost, 0);
    chkEq("R9", "ackReceived", ackReceived, 0);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // One full header; arbAt = slot where a competitor pulls SDA low (-1 none)
  task automatic sendHeader(input logic [6:0] addr, input bit rd, input bit restart,
                            input bit ackLow, input int arbAt, input bit stray,
                            input bit glitch);
    bit    arbSeen = 1'b0;
    bit    b;
    string tag;
    cmdAddr = addr;
    cmdRead = rd;
    cmdAfterRestart = restart;
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    chkEq("R1", "busy after accept", busy, 1);
    chkEq("R8", "arbLost cleared at accept", arbLost, 0);
    for (int i = 0; i < 9; i++) begin
      if (stray && i == 3) begin
        sdaIn = 1'b0;
        bitSample = 1'b1;
        @(negedge clk);
        bitSample = 1'b0;
        sdaIn = 1'b1;
        chkEq("R10", "stray sample arbLost", arbLost, 0);
        chkEq("R10", "stray sample done", done, 0);
      end
      if (glitch && i == 4) begin
        cmdAddr = ~addr;
        cmdRead = ~rd;
        cmdAfterRestart = ~restart;
        cmdValid = 1'b1;
        @(negedge clk);
        cmdValid = 1'b0;
        cmdAddr = addr;
        cmdRead = rd;
        cmdAfterRestart = restart;
        chkEq("R1", "busy during ignored command", busy, 1);
      end
      bitDrive = 1'b1;
      @(negedge clk);
      bitDrive = 1'b0;
      if (i < 8) begin
        b = (i < 7) ? addr[6-i] : rd;
        tag = arbSeen ? "R8" : (i == 7) ? "R5" : restart ? "R4" : "R3";
        chkEq(tag, $sformatf("bit %0d sdaOe", i), sdaOe,
              arbSeen ? 0 : (restart ? 1 : int'(!b)));
        if (!arbSeen && restart) chkEq("R2", $sformatf("bit %0d sdaOut", i), sdaOut, b);
        if (!arbSeen && !restart) chkEq("R3", $sformatf("bit %0d sdaOut", i), sdaOut, 0);
        chkEq("R4", $sformatf("bit %0d pushPull", i), pushPull, int'(restart && !arbSeen));
        sdaIn = (sdaOe ? sdaOut : 1'b1) & (i != arbAt);
        bitSample = 1'b1;
        @(negedge clk);
        bitSample = 1'b0;
        sdaIn = 1'b1;
        if (!restart && b && i == arbAt) arbSeen = 1'b1;
        chkEq("R8", $sformatf("arbLost after bit %0d", i), arbLost, arbSeen);
        chkEq("R7", "no early done", done, 0);
      end else begin
        chkEq("R6", "ack slot sdaOe", sdaOe, 0);
        sdaIn = ackLow ? 1'b0 : 1'b1;
        bitSample = 1'b1;
        @(negedge clk);
        bitSample = 1'b0;
        sdaIn = 1'b1;
        chkEq("R7", "done pulse", done, 1);
        chkEq("R7", "ackReceived", ackReceived, ackLow);
        chkEq("R7", "busy low at done", busy, 0);
        chkEq("R8", "arbLost held at done", arbLost, arbSeen);
        @(negedge clk);
        chkEq("R7", "done single cycle", done, 0);
        chkEq("R7", "ackReceived held", ackReceived, ackLow);
      end
    end
  endtask

  initial begin
    testReset();
    sendHeader(7'h5A, 1'b0, 1'b0, 1'b1, -1, 1'b0, 1'b0); // open-drain write, ACK
    sendHeader(7'h33, 1'b1, 1'b1, 1'b1, -1, 1'b0, 1'b0); // push-pull read, ACK
    sendHeader(7'h7F, 1'b1, 1'b0, 1'b0, -1, 1'b0, 1'b0); // open-drain read, NACK
    sendHeader(7'h00, 1'b0, 1'b1, 1'b0, -1, 1'b0, 1'b0); // push-pull write, NACK
    sendHeader(7'h3C, 1'b0, 1'b0, 1'b1, 2, 1'b0, 1'b0);  // R8 loss on address bit
    sendHeader(7'h7F, 1'b1, 1'b1, 1'b1, 1, 1'b0, 1'b0);  // R8 push-pull, no flag
    sendHeader(7'h00, 1'b1, 1'b0, 1'b1, 7, 1'b0, 1'b0);  // R8 loss on R/W bit
    sendHeader(7'h15, 1'b0, 1'b0, 1'b1, -1, 1'b1, 1'b1); // R10 stray, R1 ignored cmd
    sendHeader(7'h6B, 1'b1, 1'b1, 1'b1, -1, 1'b1, 1'b1); // same in push-pull
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule